// File: doc/BRIEF.md
# Page Write Load Controller

This block models the write side of a byte-wide nonvolatile memory of 32768 bytes that accepts page writes. A host on a synchronous bus issues single-cycle write strobes with a 15-bit address and a data byte. The first strobe opens a load phase and fixes the page. Later strobes to the same page fill a 64-entry page latch, and a per-byte flag marks each offset that has been loaded. Offsets may arrive in any order, and reloading an offset overwrites its byte.

The load phase ends when no byte has been accepted for a parameterised number of clock cycles. A programming timer then runs for a fixed number of cycles with `busy` high. After that, the flagged bytes are written one per cycle through a commit port into an external behavioural storage array, in ascending offset order. Bytes that were not loaded are never written. `busy` drops on the cycle after the last commit, and a new operation may start at once.

Top module: `page_load_ctrl`

## Requirements
- R1: Address bits 14:6 select the page and bits 5:0 the byte offset. Every commit of an operation carries the page of the first strobe in bits 14:6 and the committed offset in bits 5:0.
- R2: One operation accepts from 1 to 64 bytes. `busy` stays low during the load phase.
- R3: A byte is accepted when it arrives no more than WIN_CYC cycles after the previously accepted byte. If WIN_CYC cycles pass with no accepted byte, programming starts and `busy` is high from the next cycle.
- R4: During loading, a strobe whose page bits differ from the latched page is ignored: it is not stored and it does not restart the window. It sets `page_err`, which stays set until reset.
- R5: Loading an offset a second time in the same operation replaces its data. That offset is committed once, with the last value.
- R6: Only loaded offsets are committed. Each is committed exactly once, in ascending offset order, one per cycle with `commit_en` high.
- R7: After the load phase closes, `busy` stays high for PROG_CYC cycles with no commit before the first commit.
- R8: Strobes that arrive while `busy` is high are ignored. They do not change the stored data or `page_err`.
- R9: `busy` falls on the cycle after the last commit. The loaded flags are then clear, so the next operation commits only its own bytes.
- R10: After reset, `busy`, `commit_en` and `page_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_addr | input | 15 | Byte address: page in 14:6, offset in 5:0 |
| wr_data | input | 8 | Byte to load |
| busy | output | 1 | High while programming and committing |
| page_err | output | 1 | Sticky flag: a strobe to another page was seen during loading |
| commit_en | output | 1 | Write enable to the storage array |
| commit_addr | output | 15 | Array address of the committed byte |
| commit_data | output | 8 | Committed byte |

## Verification
The bench probes the window edge from both sides. A byte that arrives exactly WIN_CYC cycles after the previous one must join the same operation. A byte one cycle later must be dropped into the busy period. A design off by one in its window counter would either split the first case into two operations or merge the second into one. Other stimuli are an offset reloaded with new data, a full 64-byte page written in descending order, a foreign-page strobe in the middle of a load, and a strobe sent during programming. A design that got these wrong would commit stale data, commit an offset twice, commit bytes out of order, store the foreign byte or the late byte, or clear the error flag. A final write of one byte to a page used earlier checks that the flags were cleared: a leftover flag would rewrite an old offset.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } pl_state_e;
endpackage

// File: rtl/pl_cycle_timer.sv
// Counts enabled cycles since the last clear; expire flags the final counted cycle.
module pl_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = en && !clr && (cnt_q == CW'(LIMIT - 1));

  // R3/R7: an expiry never happens with the count cleared the cycle before
  p_expire_after_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !$past(clr) || (LIMIT == 1));
endmodule

// File: rtl/pl_page_buf.sv
// Page latch with per-offset loaded flags and lowest-offset selection for commit.
module pl_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              pop,
  output logic [OFF_W-1:0]  sel_off,
  output logic [DATA_W-1:0] sel_data,
  output logic              any,
  output logic              last
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DEPTH-1:0]  flag_q, flag_d;
  logic [DATA_W-1:0] byte_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (ld_en && (ld_off == OFF_W'(g))) byte_q[g] <= ld_data;
    end
  end

  always_comb begin
    sel_off = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (flag_q[i]) sel_off = OFF_W'(i);
    end
  end

  assign sel_data = byte_q[sel_off];
  assign any      = |flag_q;
  assign last     = any && ((flag_q & (flag_q - 1'b1)) == '0);

  always_comb begin
    flag_d = flag_q;
    if (pop)   flag_d[sel_off] = 1'b0;
    if (ld_en) flag_d[ld_off]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  // R9: a committed offset is no longer flagged afterwards
  p_pop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !flag_q[$past(sel_off)]);
  // R8: loading and committing never overlap
  p_no_load_during_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && ld_en));
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int OFF_W    = 6,
  parameter int DATA_W   = 8,
  parameter int WIN_CYC  = 16,
  parameter int PROG_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              page_err,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  pl_state_e         st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              err_q, err_d;
  logic [PAGE_W-1:0] wr_page;
  logic [OFF_W-1:0]  wr_off, sel_off;
  logic              page_match, accept, win_exp, prog_exp, buf_any, buf_last;

  assign wr_page    = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off     = wr_addr[OFF_W-1:0];
  assign page_match = (wr_page == page_q);
  assign accept     = wr_en && ((st_q == ST_IDLE) || ((st_q == ST_LOAD) && page_match));

  pl_cycle_timer #(.LIMIT(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n),
    .clr(accept || (st_q != ST_LOAD)),
    .en(st_q == ST_LOAD),
    .expire(win_exp)
  );

  pl_cycle_timer #(.LIMIT(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .clr(st_q != ST_PROG),
    .en(st_q == ST_PROG),
    .expire(prog_exp)
  );

  pl_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .ld_en(accept), .ld_off(wr_off), .ld_data(wr_data),
    .pop(st_q == ST_COMMIT),
    .sel_off(sel_off), .sel_data(commit_data),
    .any(buf_any), .last(buf_last)
  );

  always_comb begin
    st_d   = st_q;
    page_d = page_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_LOAD;
        page_d = wr_page;
      end
      ST_LOAD: begin
        if (wr_en && !page_match) err_d = 1'b1;
        if (win_exp && !accept)   st_d  = ST_PROG;
      end
      ST_PROG:   if (prog_exp) st_d = ST_COMMIT;
      ST_COMMIT: if (buf_last) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      err_q  <= err_d;
    end
  end

  assign busy        = (st_q == ST_PROG) || (st_q == ST_COMMIT);
  assign commit_en   = (st_q == ST_COMMIT);
  assign commit_addr = {page_q, sel_off};
  assign page_err    = err_q;

  // R1: page held stable for the whole operation once loading has begun
  p_page_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) && ($past(st_q) != ST_IDLE) |-> $stable(page_q));
  // R3: busy only rises on a window expiry
  p_busy_on_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_exp));
  // R4: error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  // R6: commit phase always has a flagged byte to write
  p_commit_has_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> buf_any);
  // R7: first commit follows a programming timer expiry
  p_commit_after_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_en) |-> $past(prog_exp));
  // R8: no byte is accepted while busy
  p_busy_blocks_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  // R9: busy falls only right after the last flagged byte was committed
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit_en) && $past(buf_last));
endmodule

// File: tb/tb_page_load_ctrl.sv
module tb_page_load_ctrl;
  localparam int WIN  = 8;
  localparam int PROG = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy, page_err, commit_en;
  logic [14:0] commit_addr;
  logic [7:0]  commit_data;

  int total = 0;
  int bad   = 0;

  page_load_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .page_err(page_err), .commit_en(commit_en),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always #4 clk = ~clk;

  // behavioural reference: mode 0 idle, 1 loading, 2 programming, 3 committing
  int         m_mode = 0, m_gap = 0, m_prog = 0;
  logic [8:0] m_page = '0;
  bit         m_err = 1'b0;
  logic [7:0] m_lat [int];

  // storage array fed by the commit port
  logic [7:0] arr [int];
  int         ccount = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_gap = 0; m_prog = 0; m_err = 1'b0; m_lat.delete();
    end else begin
      if (commit_en) begin
        arr[int'(commit_addr)] = commit_data;
        ccount++;
      end
      case (m_mode)
        0: if (wr_en) begin
          m_page = wr_addr[14:6];
          m_lat.delete();
          m_lat[int'(wr_addr[5:0])] = wr_data;
          m_gap = 0; m_mode = 1;
        end
        1: if (wr_en && wr_addr[14:6] == m_page) begin
          m_lat[int'(wr_addr[5:0])] = wr_data;
          m_gap = 0;
        end else begin
          if (wr_en) m_err = 1'b1;
          if (m_gap == WIN - 1) begin m_mode = 2; m_prog = 0; end
          else m_gap++;
        end
        2: if (m_prog == PROG - 1) m_mode = 3; else m_prog++;
        default: begin
          int k;
          void'(m_lat.first(k));
          m_lat.delete(k);
          if (m_lat.num() == 0) m_mode = 0;
        end
      endcase
    end
  end

  // per-cycle comparison, sampled between edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        string rq;
        rq = (m_mode == 2) ? "R7" : (m_mode == 3) ? "R9" : "R3";
        chk(busy === (m_mode >= 2), rq, "busy", 32'(busy), 32'(m_mode >= 2));
        chk(page_err === m_err, "R4", "page_err", 32'(page_err), 32'(m_err));
        chk(commit_en === (m_mode == 3), "R6", "commit_en", 32'(commit_en), 32'(m_mode == 3));
        if (m_mode == 3) begin
          int k;
          void'(m_lat.first(k));
          chk(commit_addr[14:6] === m_page, "R1", "commit page", 32'(commit_addr[14:6]), 32'(m_page));
          chk(commit_addr[5:0] === 6'(k), "R6", "commit offset", 32'(commit_addr[5:0]), 32'(k));
          chk(commit_data === m_lat[k], "R5", "commit data", 32'(commit_data), 32'(m_lat[k]));
        end
      end
    end
  end

  task automatic wr(input logic [8:0] pg, input logic [5:0] off, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = {pg, off}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!busy && k < 1000) begin @(negedge clk); k++; end
    while (busy && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  function automatic bit has(input int a);
    return arr.exists(a);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy === 1'b0 && commit_en === 1'b0 && page_err === 1'b0, "R10", "reset outputs",
        {busy, commit_en, page_err}, 0);

    // single byte (R2)
    ccount = 0;
    wr(9'd3, 6'd10, 8'h5A);
    chk(busy === 1'b0, "R2", "busy during load", 32'(busy), 0);
    wait_done();
    chk(ccount == 1, "R2", "single-byte commits", ccount, 1);
    chk(has(3*64+10) && arr[3*64+10] == 8'h5A, "R1", "byte at page 3 offset 10",
        has(3*64+10) ? arr[3*64+10] : 32'hDEAD, 8'h5A);

    // scrambled order with reload (R5, R6)
    ccount = 0;
    wr(9'd7, 6'd40, 8'h40); idle(WIN - 1);
    wr(9'd7, 6'd2, 8'h02);  idle(3);
    wr(9'd7, 6'd63, 8'h63);
    wr(9'd7, 6'd2, 8'h99);  idle(WIN - 2);
    wr(9'd7, 6'd0, 8'h00);
    wait_done();
    chk(ccount == 4, "R5", "distinct offsets committed once", ccount, 4);
    chk(has(7*64+2) && arr[7*64+2] == 8'h99, "R5", "reloaded byte",
        has(7*64+2) ? arr[7*64+2] : 32'hDEAD, 8'h99);
    chk(!has(7*64+1), "R6", "unloaded offset untouched", 32'(has(7*64+1)), 0);

    // full page descending (R2)
    ccount = 0;
    for (int i = 63; i >= 0; i--) wr(9'd100, 6'(i), 8'(i) ^ 8'hC3);
    wait_done();
    chk(ccount == 64, "R2", "full page commits", ccount, 64);
    chk(arr[100*64+0] == 8'hC3 && arr[100*64+63] == (8'd63 ^ 8'hC3), "R2", "page ends",
        {arr[100*64+0], arr[100*64+63]}, {8'hC3, 8'd63 ^ 8'hC3});

    // foreign page during load (R4)
    ccount = 0;
    wr(9'd20, 6'd1, 8'h11);
    wr(9'd21, 6'd1, 8'h22);
    wr(9'd20, 6'd3, 8'h33);
    chk(page_err === 1'b1, "R4", "error flag set", 32'(page_err), 1);
    wait_done();
    chk(ccount == 2 && !has(21*64+1), "R4", "foreign byte dropped", ccount, 2);

    // strobe during busy (R8)
    ccount = 0;
    wr(9'd30, 6'd4, 8'h44); idle(WIN + 2);
    chk(busy === 1'b1, "R3", "busy after window", 32'(busy), 1);
    wr(9'd30, 6'd5, 8'h55);
    wait_done();
    chk(ccount == 1 && !has(30*64+5), "R8", "busy-time strobe ignored", ccount, 1);
    chk(page_err === 1'b1, "R8", "error flag unchanged", 32'(page_err), 1);

    // window boundary: exactly WIN cycles joins, WIN+1 does not (R3)
    ccount = 0;
    wr(9'd40, 6'd1, 8'hA1); idle(WIN - 1);
    wr(9'd40, 6'd2, 8'hA2);
    wait_done();
    chk(ccount == 2, "R3", "byte at window edge accepted", ccount, 2);
    ccount = 0;
    wr(9'd41, 6'd1, 8'hB1); idle(WIN);
    wr(9'd41, 6'd2, 8'hB2);
    wait_done();
    chk(ccount == 1 && !has(41*64+2), "R3", "late byte dropped", ccount, 1);

    // flags cleared between operations (R9)
    ccount = 0;
    wr(9'd7, 6'd5, 8'h77);
    wait_done();
    chk(ccount == 1, "R9", "only new byte committed", ccount, 1);
    chk(arr[7*64+2] == 8'h99 && arr[7*64+5] == 8'h77, "R9", "old byte kept",
        {arr[7*64+2], arr[7*64+5]}, {8'h99, 8'h77});
    chk(busy === 1'b0, "R9", "idle after commit", 32'(busy), 0);

    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule